// File: doc/BRIEF.md
# Signaling Change Detector with Address FIFO

This block watches the 6-bit signaling field carried in every upstream timeslot of a time-division frame. It keeps track of up to 32 channels, one per (port, timeslot) pair. Each channel has its own enable, detection state, reference value and candidate value. Software preloads an expected value and then enables a channel. The channel stays silent until the line delivers exactly that value. From then on it is armed. A new value that is seen in two consecutive frames counts as a valid change: the block stores the channel's address in an 8-entry FIFO and makes the new value the reference.

A processor services the block over a small register bus with eight 8-bit registers. The interrupt line stays high while the FIFO holds at least one address. To service it, the processor reads the FIFO, which pops the oldest entry, and writes that address to the access-address register. It then writes the access-command register, polls the busy bit until it clears, and reads the validated signaling value from the access-data register. A change that finds the FIFO full is dropped, and a sticky overflow bit is set.

Top module: `sigchg_detect`

## Requirements
- R1: After reset, `irq` is 0, a read of STATUS (offset 0) returns 0, a read of the FIFO (offset 1) returns 0, the busy bit (offset 3, bit 0) is 0, and every channel is disabled.
- R2: A CTRL write (offset 6) with bit 7 set enables the channel in bits 4:0, which is the index {port[1:0], ts[2:0]}. The write loads the EXPECT register (offset 5, bits 5:0) as that channel's reference. When the channel's next slot carries the reference value, the channel arms, and no FIFO entry and no interrupt result.
- R3: A channel that is disabled (CTRL bit 7 clear), or enabled but not yet armed, never pushes an entry, whatever values its slots carry.
- R4: An armed channel that receives a value different from its reference, and receives the same value again in its next slot, pushes the address {1'b1, port[1:0], ts[2:0]} (port 2, timeslot 7 gives 0x37). That value then becomes the reference.
- R5: A differing value that appears in only one slot, followed by the reference value or by another different value, pushes nothing. A third different value restarts confirmation with the newest value.
- R6: Once a change has been validated, further slots carrying the same value push nothing.
- R7: `irq` and STATUS bit 0 are 1 exactly while the FIFO is non-empty. A FIFO read returns the oldest address in bits 5:0 and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R8: The FIFO holds 8 entries. A push into a full FIFO with no pop in the same cycle drops the entry and sets the overflow bit (STATUS bit 1). The bit stays set until STATUS is written with bit 1 set. If that clear and a new overflow fall in the same cycle, the bit stays set.
- R9: A push and a FIFO read in the same cycle both take effect, including when the FIFO is full. In that case nothing is dropped and overflow is not set.
- R10: A write to CMD (offset 3) while idle holds the busy bit high for exactly two cycles. By the time busy clears, DATA (offset 4, bits 5:0) holds the reference of the channel given by bits 4:0 of ADDR (offset 2). Bit 5 of ADDR is not used for the lookup. A CMD write while busy is ignored.
- R11: When a CTRL write and a slot for the same channel fall in the same cycle, the CTRL write wins and the slot is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 1 | Upstream slot strobe for the current cycle |
| slot_port | input | 2 | Port index of the strobed slot |
| slot_ts | input | 3 | Timeslot index of the strobed slot |
| slot_sig | input | 6 | Received signaling field |
| cpu_rd | input | 1 | Register read strobe (a read of the FIFO pops it) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from cpu_addr |
| irq | output | 1 | High while the change FIFO is non-empty |

## Verification
Two events can collide in one cycle. The first is a confirming slot that pushes an address while the processor reads the FIFO. The bench provokes this both with the FIFO partly filled and with it exactly full. The behavioural queue model predicts `irq` and every read value on each clock, so a lost entry, a wrongly dropped entry or a spurious overflow shows up at once. The second collision is a CTRL write that lands in the same cycle as a slot for the same channel. The bench judges it by whether the next matching slot arms the channel silently.

// File: rtl/sigchg_pkg.sv
package sigchg_pkg;
    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_WAIT    = 2'd1,
        CH_ARMED   = 2'd2,
        CH_CONFIRM = 2'd3
    } ch_state_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_LOAD  = 2'd2
    } acc_state_t;

    localparam logic [2:0] REG_STATUS = 3'd0;
    localparam logic [2:0] REG_FIFO   = 3'd1;
    localparam logic [2:0] REG_ADDR   = 3'd2;
    localparam logic [2:0] REG_CMD    = 3'd3;
    localparam logic [2:0] REG_DATA   = 3'd4;
    localparam logic [2:0] REG_EXPECT = 3'd5;
    localparam logic [2:0] REG_CTRL   = 3'd6;
endpackage

// File: rtl/sigchg_fifo.sv
module sigchg_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop_req,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop, do_push;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop_req && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem_q[rp_q];
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem_q[wp_q] <= din;
                wp_q        <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop)
                rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sigchg_tracker.sv
module sigchg_tracker
    import sigchg_pkg::*;
#(
    parameter int SIG_W = 6,
    parameter int CH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_vld,
    input  logic [CH_W-1:0]  slot_ch,
    input  logic [SIG_W-1:0] slot_sig,
    input  logic             ctl_vld,
    input  logic             ctl_en,
    input  logic [CH_W-1:0]  ctl_ch,
    input  logic [SIG_W-1:0] ctl_ref,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [SIG_W-1:0] rd_ref,
    output logic             chg_push
);
    localparam int NCH = 1 << CH_W;

    ch_state_t        st_q   [NCH];
    logic [SIG_W-1:0] ref_q  [NCH];
    logic [SIG_W-1:0] cand_q [NCH];

    ch_state_t        cur_st, nxt_st;
    logic [SIG_W-1:0] cur_ref, cur_cand, nxt_ref, nxt_cand;
    logic             hit, slot_take;

    assign slot_take = slot_vld && !(ctl_vld && ctl_ch == slot_ch);
    assign chg_push  = slot_take && hit;
    assign rd_ref    = ref_q[rd_ch];

    // next-state for the channel owning the current slot
    always_comb begin
        cur_st   = st_q[slot_ch];
        cur_ref  = ref_q[slot_ch];
        cur_cand = cand_q[slot_ch];
        nxt_st   = cur_st;
        nxt_ref  = cur_ref;
        nxt_cand = cur_cand;
        hit      = 1'b0;
        unique case (cur_st)
            CH_OFF: ;
            CH_WAIT:
                if (slot_sig == cur_ref) nxt_st = CH_ARMED;
            CH_ARMED:
                if (slot_sig != cur_ref) begin
                    nxt_st   = CH_CONFIRM;
                    nxt_cand = slot_sig;
                end
            CH_CONFIRM:
                if (slot_sig == cur_cand) begin
                    nxt_st  = CH_ARMED;
                    nxt_ref = cur_cand;
                    hit     = 1'b1;
                end else if (slot_sig == cur_ref) begin
                    nxt_st = CH_ARMED;
                end else begin
                    nxt_cand = slot_sig;
                end
            default: nxt_st = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                st_q[i]   <= CH_OFF;
                ref_q[i]  <= '0;
                cand_q[i] <= '0;
            end
        end else begin
            if (slot_take) begin
                st_q[slot_ch]   <= nxt_st;
                ref_q[slot_ch]  <= nxt_ref;
                cand_q[slot_ch] <= nxt_cand;
            end
            if (ctl_vld) begin
                st_q[ctl_ch]  <= ctl_en ? CH_WAIT : CH_OFF;
                ref_q[ctl_ch] <= ctl_ref;
            end
        end
    end
endmodule

// File: rtl/sigchg_access.sv
module sigchg_access
    import sigchg_pkg::*;
#(
    parameter int SIG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SIG_W-1:0] ref_in,
    output logic             busy,
    output logic [SIG_W-1:0] data
);
    acc_state_t st_q, st_d;
    logic [SIG_W-1:0] data_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE:  if (start) st_d = ACC_FETCH;
            ACC_FETCH: st_d = ACC_LOAD;
            ACC_LOAD:  st_d = ACC_IDLE;
            default:   st_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (st_q == ACC_FETCH) data_q <= ref_in;
    end

    assign busy = (st_q != ACC_IDLE);
    assign data = data_q;
endmodule

// File: rtl/sigchg_detect.sv
module sigchg_detect
    import sigchg_pkg::*;
#(
    parameter int SIG_W      = 6,
    parameter int PORT_W     = 2,
    parameter int TS_W       = 3,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_vld,
    input  logic [PORT_W-1:0] slot_port,
    input  logic [TS_W-1:0]   slot_ts,
    input  logic [SIG_W-1:0]  slot_sig,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              irq
);
    localparam int CH_W   = PORT_W + TS_W;
    localparam int ADDR_W = CH_W + 1;
    localparam int CNT_W  = $clog2(FIFO_DEPTH+1);

    logic [SIG_W-1:0]  expect_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic              ovf_q;
    logic [CH_W-1:0]   slot_ch;
    logic              chg_push, fifo_pop, fifo_empty, fifo_full;
    logic [ADDR_W-1:0] fifo_dout;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [SIG_W-1:0]  rd_ref, acc_data;
    logic              acc_busy, ctl_vld;
    logic              unused_bits;

    assign slot_ch  = {slot_port, slot_ts};
    assign fifo_pop = cpu_rd && cpu_addr == REG_FIFO;
    assign ctl_vld  = cpu_wr && cpu_addr == REG_CTRL;
    assign irq      = !fifo_empty;
    assign unused_bits = ^{cpu_wdata[6:CH_W], acc_addr_q[ADDR_W-1]};

    sigchg_tracker #(.SIG_W(SIG_W), .CH_W(CH_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .slot_vld(slot_vld), .slot_ch(slot_ch), .slot_sig(slot_sig),
        .ctl_vld(ctl_vld), .ctl_en(cpu_wdata[7]), .ctl_ch(cpu_wdata[CH_W-1:0]),
        .ctl_ref(expect_q), .rd_ch(acc_addr_q[CH_W-1:0]), .rd_ref(rd_ref),
        .chg_push(chg_push)
    );

    sigchg_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(chg_push), .pop_req(fifo_pop),
        .din({1'b1, slot_ch}), .dout(fifo_dout), .empty(fifo_empty),
        .full(fifo_full), .cnt(fifo_cnt)
    );

    sigchg_access #(.SIG_W(SIG_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .start(cpu_wr && cpu_addr == REG_CMD),
        .ref_in(rd_ref), .busy(acc_busy), .data(acc_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_q   <= '0;
            acc_addr_q <= '0;
            ovf_q      <= 1'b0;
        end else begin
            if (cpu_wr && cpu_addr == REG_EXPECT) expect_q   <= cpu_wdata[SIG_W-1:0];
            if (cpu_wr && cpu_addr == REG_ADDR)   acc_addr_q <= cpu_wdata[ADDR_W-1:0];
            if (chg_push && fifo_full && !(fifo_pop && !fifo_empty))
                ovf_q <= 1'b1;
            else if (cpu_wr && cpu_addr == REG_STATUS && cpu_wdata[1])
                ovf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (cpu_addr)
            REG_STATUS: cpu_rdata = {6'b0, ovf_q, !fifo_empty};
            REG_FIFO:   cpu_rdata = fifo_empty ? 8'h00 : 8'(fifo_dout);
            REG_ADDR:   cpu_rdata = 8'(acc_addr_q);
            REG_CMD:    cpu_rdata = {7'b0, acc_busy};
            REG_DATA:   cpu_rdata = 8'(acc_data);
            REG_EXPECT: cpu_rdata = 8'(expect_q);
            default:    cpu_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sigchg_detect_chk.sv
module sigchg_detect_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          cpu_rd,
    input logic          cpu_wr,
    input logic [2:0]    cpu_addr,
    input logic [7:0]    cpu_wdata,
    input logic          busy,
    input logic          ovf,
    input logic          push,
    input logic          full,
    input logic [CW-1:0] cnt
);
    logic rd_fifo, clr_ovf;
    assign rd_fifo = cpu_rd && cpu_addr == 3'd1;
    assign clr_ovf = cpu_wr && cpu_addr == 3'd0 && cpu_wdata[1];

    p_irq_fall_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_fifo));
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !rd_fifo) |=> ovf);
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);
    p_full_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && rd_fifo) |=> (cnt == $past(cnt) && $stable(ovf)));
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 3'd3 && !busy) |=> busy);
    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);
endmodule

bind sigchg_detect sigchg_detect_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .busy(acc_busy), .ovf(ovf_q),
    .push(chg_push), .full(fifo_full), .cnt(fifo_cnt)
);

// File: tb/sigchg_detect_test.sv
module sigchg_detect_test;
    logic clk = 0, rst_n = 0;
    logic       b_sv = 0, b_rd = 0, b_wr = 0;
    logic [1:0] b_port = 0;
    logic [2:0] b_ts = 0, b_addr = 0;
    logic [5:0] b_sig = 0;
    logic [7:0] b_wd = 0;
    logic [7:0] rdata;
    logic       irq;
    int vectors = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    sigchg_detect uut (
        .clk(clk), .rst_n(rst_n), .slot_vld(b_sv), .slot_port(b_port),
        .slot_ts(b_ts), .slot_sig(b_sig), .cpu_rd(b_rd), .cpu_wr(b_wr),
        .cpu_addr(b_addr), .cpu_wdata(b_wd), .cpu_rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    int       m_st [32];
    bit [5:0] m_ref [32], m_cand [32];
    bit [5:0] m_q [$];
    bit       m_ovf;
    bit [5:0] m_expect, m_accaddr, m_data;
    int       m_phase;

    function automatic bit [7:0] model_read(input bit [2:0] a);
        case (a)
            3'd0: return {6'b0, m_ovf, m_q.size() > 0};
            3'd1: return (m_q.size() > 0) ? {2'b0, m_q[0]} : 8'h00;
            3'd2: return {2'b0, m_accaddr};
            3'd3: return {7'b0, m_phase != 0};
            3'd4: return {2'b0, m_data};
            3'd5: return {2'b0, m_expect};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  ch, cc;
        bit  coll, push;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin m_st[i] = 0; m_ref[i] = 0; m_cand[i] = 0; end
            m_q.delete(); m_ovf = 0; m_expect = 0; m_accaddr = 0; m_data = 0; m_phase = 0;
        end else begin
            ch = {b_port, b_ts};
            cc = b_wd[4:0];
            coll = b_wr && b_addr == 3'd6 && cc == ch;
            push = 0;
            if (m_phase == 2) begin m_data = m_ref[m_accaddr[4:0]]; m_phase = 1; end
            else if (m_phase == 1) m_phase = 0;
            else if (b_wr && b_addr == 3'd3) m_phase = 2;
            if (b_sv && !coll) begin
                case (m_st[ch])
                    1: if (b_sig == m_ref[ch]) m_st[ch] = 2;
                    2: if (b_sig != m_ref[ch]) begin m_st[ch] = 3; m_cand[ch] = b_sig; end
                    3: if (b_sig == m_cand[ch]) begin m_st[ch] = 2; m_ref[ch] = b_sig; push = 1; end
                       else if (b_sig == m_ref[ch]) m_st[ch] = 2;
                       else m_cand[ch] = b_sig;
                    default: ;
                endcase
            end
            if (b_wr && b_addr == 3'd6) begin
                m_st[cc] = b_wd[7] ? 1 : 0;
                m_ref[cc] = m_expect;
            end
            if (b_wr && b_addr == 3'd5) m_expect = b_wd[5:0];
            if (b_wr && b_addr == 3'd2) m_accaddr = b_wd[5:0];
            if (b_rd && b_addr == 3'd1 && m_q.size() > 0) void'(m_q.pop_front());
            if (b_wr && b_addr == 3'd0 && b_wd[1]) m_ovf = 0;
            if (push) begin
                if (m_q.size() < 8) m_q.push_back({1'b1, b_port, b_ts});
                else m_ovf = 1;
            end
        end
    end

    task automatic check(input string what, input bit [7:0] act, input bit [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit sv, input bit [1:0] p, input bit [2:0] t, input bit [5:0] s,
                       input bit rd, input bit wr, input bit [2:0] a, input bit [7:0] wd);
        @(negedge clk);
        b_sv = sv; b_port = p; b_ts = t; b_sig = s;
        b_rd = rd; b_wr = wr; b_addr = a; b_wd = wd;
        #1;
        check("irq", {7'b0, irq}, {7'b0, m_q.size() > 0});
        if (rd) check($sformatf("read reg %0d", a), rdata, model_read(a));
    endtask

    task automatic slot(input bit [1:0] p, input bit [2:0] t, input bit [5:0] s);
        cyc(1, p, t, s, 0, 0, 0, 0);
    endtask
    task automatic rd(input bit [2:0] a);
        cyc(0, 0, 0, 0, 1, 0, a, 0);
    endtask
    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        cyc(0, 0, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1"; rd(0); rd(1); rd(3); rd(4);
        // R2 enable channel port2/ts7 (index 23) with expected 011101
        cur_req = "R2"; wr(5, 8'h1D); wr(6, 8'h80 | 8'd23); slot(2, 7, 6'h1D); rd(0);
        // R3 disabled and waiting channels stay silent
        cur_req = "R3";
        slot(1, 3, 6'h01); slot(1, 3, 6'h01); slot(1, 3, 6'h02); slot(1, 3, 6'h02);
        wr(5, 8'h2A); wr(6, 8'h80 | 8'd4);
        slot(0, 4, 6'h11); slot(0, 4, 6'h11); slot(0, 4, 6'h12); slot(0, 4, 6'h12); rd(0);
        // R4 valid change on channel 23
        cur_req = "R4"; slot(2, 7, 6'h0C); rd(0); slot(2, 7, 6'h0C); rd(0);
        // R6 repeats produce nothing more
        cur_req = "R6"; slot(2, 7, 6'h0C); slot(2, 7, 6'h0C); rd(0);
        // R5 glitches
        cur_req = "R5"; slot(2, 7, 6'h05); slot(2, 7, 6'h0C);
        slot(2, 7, 6'h05); slot(2, 7, 6'h06); slot(2, 7, 6'h06); rd(0);
        // R7 read oldest, then empty
        cur_req = "R7"; rd(1); rd(1); rd(0); rd(1);
        // R10 read-back of channel 23
        cur_req = "R10"; wr(2, 8'h37); wr(3, 8'h01); rd(3); wr(3, 8'h01); rd(3); rd(3); rd(4);
        wr(2, 8'h04); wr(3, 8'h01); rd(3); rd(3); rd(3); rd(4);
        // R8 fill past capacity
        cur_req = "R8";
        wr(5, 8'h00); wr(6, 8'h80 | 8'd4);
        slot(0, 4, 6'h00);
        for (int k = 1; k <= 10; k++) begin slot(0, 4, 6'(k)); slot(0, 4, 6'(k)); end
        rd(0);
        // R9 push and pop together while full
        cur_req = "R9"; wr(0, 8'h02); rd(0);
        slot(0, 4, 6'h20); cyc(1, 0, 4, 6'h20, 1, 0, 1, 0); rd(0);
        // R8 clear and set in same cycle: set wins
        cur_req = "R8"; slot(0, 4, 6'h21); cyc(1, 0, 4, 6'h21, 0, 1, 0, 8'h02); rd(0);
        wr(0, 8'h02); rd(0);
        // R9 push/pop with partial fill
        cur_req = "R9";
        for (int k = 0; k < 6; k++) rd(1);
        slot(0, 4, 6'h30); cyc(1, 0, 4, 6'h30, 1, 0, 1, 0); rd(0);
        for (int k = 0; k < 4; k++) rd(1);
        // R11 ctrl write collides with slot on same channel
        cur_req = "R11"; wr(5, 8'h15);
        cyc(1, 1, 1, 6'h15, 0, 1, 6, 8'h80 | 8'd9);
        slot(1, 1, 6'h15); slot(1, 1, 6'h16); slot(1, 1, 6'h16); rd(0); rd(1);
        wr(2, 8'h09); wr(3, 0); rd(3); rd(3); rd(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule